// File: doc/BRIEF.md
# Serial Receive Deframer with Frame Check

This block sits directly behind the receive bit recovery of an Ethernet port. One bit arrives on every receive clock while the carrier-active input is high. The block hunts through the preamble for the start-of-frame delimiter and discards everything up to and including it. From the next bit on, it packs bits into bytes, least significant bit first. Each finished byte goes out with a one-cycle write strobe toward a receive FIFO. A per-frame byte counter is updated at the same time.

Every bit after the delimiter also feeds a serial CRC-32 register that starts at all ones. The frame check sequence is shifted into the same register. A frame whose bits are intact therefore leaves the fixed residue 0xC704DD7B, so no separate comparison against the received check field is needed. When carrier-active falls after a delimiter was found, the block raises a one-cycle end-of-frame strobe. With it come two held status flags: the CRC verdict, and a dribble indication for a bit count that does not fill whole bytes.

Top module: `eth_rx_deser`

## Requirements
- R1: After reset, `byte_we` and `eof_valid` are 0 and `byte_count` is 0.
- R2: While `rx_active` is low, `rx_bit` is ignored: no byte strobe and no end-of-frame strobe result.
- R3: The delimiter is two consecutive 1 bits on `rx_active`, seen after at least one 1-then-0 pair within the same active period. The delimiter and all earlier bits are never output.
- R4: A 1,1 pair that is not preceded by a 1,0 pair within the active period is not taken as the delimiter.
- R5: Data bits are packed least significant bit first: the first bit after the delimiter becomes bit 0 of the first byte. `byte_data` is valid while `byte_we` is high. `byte_we` is high for exactly the one cycle after every eighth data bit is sampled.
- R6: `byte_count` is cleared when a delimiter is detected and increments by one with each byte strobe, so it reads 1 with the first byte of every frame. It holds its value otherwise, including after the frame ends.
- R7: One cycle after `rx_active` is first sampled low following a detected delimiter, `eof_valid` is high for exactly one cycle. If no delimiter was detected in that active period, there is no end-of-frame strobe and no byte strobe.
- R8: `eof_crc_ok` is 1 when the serial CRC-32 (polynomial 0x04C11DB7, register preset to all ones, data bits fed in arrival order) over data and FCS bits equals 0xC704DD7B. This is the case for a frame that ends with its correct FCS, which is the complemented reflected CRC sent least significant bit first.
- R9: A single inverted data bit makes `eof_crc_ok` 0.
- R10: `eof_dribble` is 1 when the number of data bits after the delimiter is not a multiple of 8. The trailing partial byte is never strobed out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_active | input | 1 | Carrier active; bits are taken only while high |
| rx_bit | input | 1 | Serial receive data |
| byte_data | output | DATA_W | Assembled byte, valid with `byte_we` |
| byte_we | output | 1 | One-cycle byte write strobe toward the FIFO |
| byte_count | output | CNT_W | Bytes delivered in the current frame |
| eof_valid | output | 1 | One-cycle end-of-frame strobe |
| eof_crc_ok | output | 1 | Frame check passed; held until the next frame end |
| eof_dribble | output | 1 | Frame ended on a partial byte; held until the next frame end |

## Verification
Several rules are checked by the assertions on every cycle. No strobe follows an inactive carrier sample, and byte strobes are never back to back. The end-of-frame strobe lasts one cycle and only follows a carrier drop. The byte counter changes only on a byte strobe or right after a delimiter, and then only by one step. The content of the data path can only be shown by the bench's frames: byte values and their bit order, rejection of a false 1,1 in the preamble, the CRC verdict on clean and corrupted frames, and the dribble flag.

// File: rtl/eth_rx_pkg.sv
package eth_rx_pkg;

  localparam int          CRC_W       = 32;
  localparam logic [31:0] CRC_POLY    = 32'h04C11DB7;
  localparam logic [31:0] CRC_PRESET  = 32'hFFFFFFFF;
  localparam logic [31:0] CRC_RESIDUE = 32'hC704DD7B;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HUNT = 2'd1,
    ST_DATA = 2'd2
  } rx_state_e;

  // One serial step of the CRC register, MSB-side feedback.
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] crc,
                                                 input logic             din);
    logic fb;
    fb = crc[CRC_W-1] ^ din;
    crc_step = {crc[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction

  // Delimiter condition: a 1,0 pair already seen, previous bit 1, this bit 1.
  function automatic logic is_delim(input logic pair_seen,
                                    input logic prev_bit,
                                    input logic cur_bit);
    is_delim = pair_seen & prev_bit & cur_bit;
  endfunction

endpackage

// File: rtl/rx_sfd_hunt.sv
module rx_sfd_hunt
  import eth_rx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rx_active,
  input  logic rx_bit,
  output logic sfd_hit,
  output logic data_bit_en,
  output logic frame_end
);

  rx_state_e state_q;
  logic      prev_q;
  logic      pair_q;

  assign sfd_hit     = (state_q == ST_HUNT) && rx_active && is_delim(pair_q, prev_q, rx_bit);
  assign data_bit_en = (state_q == ST_DATA) && rx_active;
  assign frame_end   = (state_q == ST_DATA) && !rx_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      prev_q  <= 1'b0;
      pair_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (rx_active) begin
            state_q <= ST_HUNT;
            prev_q  <= rx_bit;
            pair_q  <= 1'b0;
          end
        end
        ST_HUNT: begin
          if (!rx_active) begin
            state_q <= ST_IDLE;
          end else if (sfd_hit) begin
            state_q <= ST_DATA;
          end else begin
            if (prev_q && !rx_bit) pair_q <= 1'b1;
            prev_q <= rx_bit;
          end
        end
        ST_DATA: begin
          if (!rx_active) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rx_byte_asm.sv
module rx_byte_asm #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      frame_start,
  input  logic                      bit_en,
  input  logic                      rx_bit,
  output logic [DATA_W-1:0]         byte_data,
  output logic                      byte_we,
  output logic [CNT_W-1:0]          byte_count,
  output logic [$clog2(DATA_W)-1:0] bit_phase
);

  localparam int PH_W = $clog2(DATA_W);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(DATA_W - 1);

  logic [DATA_W-1:0] shreg_q;
  logic [DATA_W-1:0] shreg_nxt;
  logic              byte_done;

  assign shreg_nxt = {rx_bit, shreg_q[DATA_W-1:1]};
  assign byte_done = bit_en && (bit_phase == PH_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q    <= '0;
      bit_phase  <= '0;
      byte_data  <= '0;
      byte_we    <= 1'b0;
      byte_count <= '0;
    end else begin
      byte_we <= 1'b0;
      if (frame_start) begin
        shreg_q    <= '0;
        bit_phase  <= '0;
        byte_count <= '0;
      end else if (byte_done) begin
        byte_data  <= shreg_nxt;
        byte_we    <= 1'b1;
        byte_count <= byte_count + CNT_W'(1);
        bit_phase  <= '0;
        shreg_q    <= '0;
      end else if (bit_en) begin
        shreg_q   <= shreg_nxt;
        bit_phase <= bit_phase + PH_W'(1);
      end
    end
  end

endmodule

// File: rtl/rx_crc_chk.sv
module rx_crc_chk
  import eth_rx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic crc_init,
  input  logic bit_en,
  input  logic rx_bit,
  output logic crc_match
);

  logic [CRC_W-1:0] crc_q;

  assign crc_match = (crc_q == CRC_RESIDUE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= CRC_PRESET;
    end else if (crc_init) begin
      crc_q <= CRC_PRESET;
    end else if (bit_en) begin
      crc_q <= crc_step(crc_q, rx_bit);
    end
  end

endmodule

// File: rtl/eth_rx_deser.sv
module eth_rx_deser #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_active,
  input  logic              rx_bit,
  output logic [DATA_W-1:0] byte_data,
  output logic              byte_we,
  output logic [CNT_W-1:0]  byte_count,
  output logic              eof_valid,
  output logic              eof_crc_ok,
  output logic              eof_dribble
);

  localparam int PH_W = $clog2(DATA_W);

  logic            sfd_hit;
  logic            data_bit_en;
  logic            frame_end;
  logic            crc_match;
  logic [PH_W-1:0] bit_phase;

  rx_sfd_hunt u_hunt (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_active   (rx_active),
    .rx_bit      (rx_bit),
    .sfd_hit     (sfd_hit),
    .data_bit_en (data_bit_en),
    .frame_end   (frame_end)
  );

  rx_byte_asm #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_asm (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (sfd_hit),
    .bit_en      (data_bit_en),
    .rx_bit      (rx_bit),
    .byte_data   (byte_data),
    .byte_we     (byte_we),
    .byte_count  (byte_count),
    .bit_phase   (bit_phase)
  );

  rx_crc_chk u_crc (
    .clk       (clk),
    .rst_n     (rst_n),
    .crc_init  (sfd_hit),
    .bit_en    (data_bit_en),
    .rx_bit    (rx_bit),
    .crc_match (crc_match)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eof_valid   <= 1'b0;
      eof_crc_ok  <= 1'b0;
      eof_dribble <= 1'b0;
    end else begin
      eof_valid <= frame_end;
      if (frame_end) begin
        eof_crc_ok  <= crc_match;
        eof_dribble <= (bit_phase != '0);
      end
    end
  end

endmodule

// File: rtl/eth_rx_deser_chk.sv
module eth_rx_deser_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_active,
  input logic             byte_we,
  input logic [CNT_W-1:0] byte_count,
  input logic             eof_valid,
  input logic             sfd_hit
);

  // R2: an inactive carrier sample never yields a byte strobe
  p_idle_no_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rx_active) |-> !byte_we);

  // R5: byte strobes are never in adjacent cycles
  p_write_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_we |=> !byte_we);

  // R6: each strobe advances the counter by exactly one
  p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    byte_we |-> (byte_count == $past(byte_count) + CNT_W'(1)));

  // R6: the counter moves only on a strobe or after a delimiter
  p_count_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(byte_count) |-> (byte_we || $past(sfd_hit)));

  // R7: end-of-frame only follows an inactive carrier sample
  p_eof_after_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    eof_valid |-> !$past(rx_active));

  // R7: end-of-frame strobe lasts one cycle
  p_eof_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    eof_valid |=> !eof_valid);

  // R5, R7: byte strobe and frame end never coincide
  p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({byte_we, eof_valid}));

endmodule

bind eth_rx_deser eth_rx_deser_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_active  (rx_active),
  .byte_we    (byte_we),
  .byte_count (byte_count),
  .eof_valid  (eof_valid),
  .sfd_hit    (sfd_hit)
);

// File: tb/eth_rx_deser_bench.sv
module eth_rx_deser_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 8;
  localparam int CNT_W  = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              rx_active = 1'b0;
  logic              rx_bit = 1'b0;
  logic [DATA_W-1:0] byte_data;
  logic              byte_we;
  logic [CNT_W-1:0]  byte_count;
  logic              eof_valid;
  logic              eof_crc_ok;
  logic              eof_dribble;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  logic [7:0] fr [0:31];
  logic [7:0] cap_byte [0:63];
  int         cap_cnt  [0:63];
  int         ncap = 0;
  int         neof = 0;
  logic       last_ok = 1'b0;
  logic       last_drib = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eth_rx_deser #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_eth_rx_deser (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_active   (rx_active),
    .rx_bit      (rx_bit),
    .byte_data   (byte_data),
    .byte_we     (byte_we),
    .byte_count  (byte_count),
    .eof_valid   (eof_valid),
    .eof_crc_ok  (eof_crc_ok),
    .eof_dribble (eof_dribble)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (byte_we && ncap < 64) begin
        cap_byte[ncap] = byte_data;
        cap_cnt[ncap]  = int'(byte_count);
        ncap = ncap + 1;
      end
      if (eof_valid) begin
        neof      = neof + 1;
        last_ok   = eof_crc_ok;
        last_drib = eof_dribble;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic act, input logic b);
    @(negedge clk);
    rx_active = act;
    rx_bit    = b;
  endtask

  task automatic clear_capture();
    ncap = 0;
    neof = 0;
  endtask

  // Reflected CRC-32 over whole bytes; returns the FCS value to transmit.
  function automatic logic [31:0] ref_fcs(input int n);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++) begin
      c = c ^ {24'h0, fr[i]};
      for (int k = 0; k < 8; k++)
        c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  // Sends one frame; flip_at < 0 means no corruption.
  task automatic send_frame(input int npre, input int nbytes, input int seed,
                            input bit lead11, input int flip_at, input int extra);
    logic [31:0] fcs;
    int total;
    for (int i = 0; i < nbytes; i++) fr[i] = 8'(seed * 37 + i * 11 + 5);
    fcs = ref_fcs(nbytes);
    for (int i = 0; i < 4; i++) fr[nbytes + i] = fcs[8*i +: 8];
    total = nbytes + 4;
    clear_capture();
    if (lead11) begin
      drive(1'b1, 1'b1);
      drive(1'b1, 1'b1);
    end
    for (int i = 0; i < npre; i++) begin
      drive(1'b1, 1'b1);
      drive(1'b1, 1'b0);
    end
    drive(1'b1, 1'b1);
    drive(1'b1, 1'b1);
    for (int i = 0; i < total; i++)
      for (int b = 0; b < 8; b++)
        drive(1'b1, fr[i][b] ^ ((i * 8 + b) == flip_at));
    for (int i = 0; i < extra; i++) drive(1'b1, i[0]);
    drive(1'b0, 1'b0);
    repeat (4) drive(1'b0, 1'b0);
  endtask

  task automatic check_frame_bytes(input string req, input int total);
    check(ncap == total, {req, " byte strobes"}, ncap, total);
    for (int i = 0; i < total && i < ncap; i++) begin
      check(cap_byte[i] == fr[i], {req, " byte value"}, int'(cap_byte[i]), int'(fr[i]));
      check(cap_cnt[i] == i + 1, "R6 count with byte", cap_cnt[i], i + 1);
    end
    check(int'(byte_count) == total, "R6 count held after frame", int'(byte_count), total);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(byte_we == 1'b0, "R1 byte_we", int'(byte_we), 0);
    check(eof_valid == 1'b0, "R1 eof_valid", int'(eof_valid), 0);
    check(byte_count == '0, "R1 byte_count", int'(byte_count), 0);
  endtask

  task automatic t_good_frame();
    send_frame(7, 6, 1, 1'b0, -1, 0);
    check_frame_bytes("R3 R5 good frame", 10);
    check(neof == 1, "R7 one eof strobe", neof, 1);
    check(last_ok == 1'b1, "R8 crc ok", int'(last_ok), 1);
    check(last_drib == 1'b0, "R10 no dribble", int'(last_drib), 0);
  endtask

  task automatic t_short_preamble();
    send_frame(1, 12, 4, 1'b0, -1, 0);
    check_frame_bytes("R3 one pair preamble", 16);
    check(last_ok == 1'b1, "R8 crc ok long frame", int'(last_ok), 1);
  endtask

  task automatic t_corrupt();
    send_frame(5, 6, 2, 1'b0, 13, 0);
    check(neof == 1, "R7 eof on bad frame", neof, 1);
    check(last_ok == 1'b0, "R9 crc bad", int'(last_ok), 0);
    check(ncap == 10, "R9 bytes still written", ncap, 10);
  endtask

  task automatic t_false_sync();
    send_frame(3, 5, 3, 1'b1, -1, 0);
    check_frame_bytes("R4 leading 1,1 ignored", 9);
    check(last_ok == 1'b1, "R4 crc ok after false 1,1", int'(last_ok), 1);
  endtask

  task automatic t_dribble();
    send_frame(4, 6, 5, 1'b0, -1, 3);
    check(ncap == 10, "R10 partial byte not written", ncap, 10);
    check(neof == 1, "R7 eof after dribble", neof, 1);
    check(last_drib == 1'b1, "R10 dribble flagged", int'(last_drib), 1);
  endtask

  task automatic t_idle_noise();
    int cnt_before;
    cnt_before = int'(byte_count);
    clear_capture();
    for (int i = 0; i < 40; i++) drive(1'b0, (i % 3) != 0);
    repeat (3) drive(1'b0, 1'b0);
    check(ncap == 0, "R2 no bytes while inactive", ncap, 0);
    check(neof == 0, "R2 no eof while inactive", neof, 0);
    check(int'(byte_count) == cnt_before, "R2 count unchanged", int'(byte_count), cnt_before);
  endtask

  task automatic t_no_delim();
    clear_capture();
    for (int i = 0; i < 20; i++) begin
      drive(1'b1, 1'b1);
      drive(1'b1, 1'b0);
    end
    drive(1'b0, 1'b0);
    repeat (4) drive(1'b0, 1'b0);
    check(ncap == 0, "R7 no bytes without delimiter", ncap, 0);
    check(neof == 0, "R7 no eof without delimiter", neof, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_good_frame();
    t_idle_noise();
    t_corrupt();
    t_false_sync();
    t_no_delim();
    t_dribble();
    t_short_preamble();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

endmodule